// File: doc/BRIEF.md
# SPI Register-Access Slave Controller

This block is a mode-0 SPI target that opens a small register file to a host over four wires. The host drops chip select and sends three kinds of byte in turn. First comes a command byte: a fixed five-bit pattern, two device-select bits and a direction flag. Next comes the register index. After that come any number of data bytes, which are written into the file or shifted back out on the serial output. Up to four targets can share one chip select when device-select matching is switched on. Each target compares the two select bits of the command with its own strap pins.

All SPI pins are brought into the system clock domain through synchronisers, and every action happens on system clock edges. The serial clock must therefore be several times slower than the system clock. The register file is outside the block. The block gives it a combinational read index, and a one-cycle write strobe with its own index and data. Two static configuration inputs choose whether the register pointer steps forward after each data byte or stays put, and whether device-select matching is in force.

Top module: `spi_regacc_slave`

## Requirements
- R1: A write frame has three parts: command byte, index byte, then data bytes. Each complete data byte produces exactly one single-cycle `rf_we` pulse, with `rf_waddr` equal to the current pointer and `rf_wdata` equal to the byte, taken MSB first.
- R2: The command byte is accepted only if its top five bits are 0,1,0,0,0. Bit 0 selects the direction, 1 for read and 0 for write. A command with any other top pattern makes the rest of the frame produce no write and leaves `spi_so_oe` low.
- R3: When `cfg_addr_en` is 1, the command is accepted only if its bits 2:1 equal `strap_addr`. When `cfg_addr_en` is 0, those two bits have no effect.
- R4: When `cfg_seq_hold` is 0, the pointer advances by one after each data byte. After index `LAST_REG` (10 by default) it goes back to 0.
- R5: When `cfg_seq_hold` is 1, the pointer keeps its value for the whole frame. Every data byte then writes to, or reads from, the index given in the index byte.
- R6: In a read frame, each data byte is driven on `spi_so` MSB first and holds `rf_rdata` at the pointer. The output changes on SCK falling edges, and the first bit is valid before the first rising edge of the data byte.
- R7: If chip select rises while a data byte is only partly received, that byte is discarded and nothing is written.
- R8: `spi_so_oe` is high only during the data phase of an accepted read frame. It is low during the command byte and the index byte, and in every write frame.
- R9: Raising chip select at any point resets the bit and byte framing. The next frame is then decoded from its first bit as a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from host |
| spi_so | output | 1 | Serial data to host |
| spi_so_oe | output | 1 | Output enable for `spi_so` |
| strap_addr | input | 2 | Device-select strap pins |
| cfg_seq_hold | input | 1 | 1 = pointer holds, 0 = pointer advances |
| cfg_addr_en | input | 1 | 1 = compare command select bits with straps |
| rf_raddr | output | ADDR_W | Register-file read index |
| rf_rdata | input | 8 | Register-file read data |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | ADDR_W | Register-file write index |
| rf_wdata | output | 8 | Register-file write data |

## Verification
The bench runs every combination of strap value, command select bits and matching enable. A decoder that compared the wrong bits, or ignored the enable, would write where it should not, or fail to write where it should. It flips each prefix bit in turn, so a partial prefix check that lets a bad command through is caught. Long write and read bursts cross the end of the map in both pointer modes; a wrong wrap point or a pointer that moves in hold mode puts data at the wrong index. Frames cut off partway through a data byte or a command byte are also sent. A design that commits partial bytes, or carries the bit count over into the next frame, would corrupt the register file or misread the next command.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;
   localparam int BYTE_W = 8;
   localparam logic [4:0] CMD_PREFIX = 5'b01000;

   typedef enum logic [2:0] {
      PH_CMD  = 3'd0,
      PH_IDX  = 3'd1,
      PH_WR   = 3'd2,
      PH_RD   = 3'd3,
      PH_SKIP = 3'd4
   } phase_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
   parameter int WIDTH = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= RST_VAL;
         end else if (s == 0) begin
            stage_q[s] <= d_in;
         end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter
   import spi_regacc_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_active,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              si,
   input  logic              load_en,
   input  logic [BYTE_W-1:0] load_data,
   output logic [$clog2(BYTE_W)-1:0] bit_cnt,
   output logic              byte_done,
   output logic [BYTE_W-1:0] byte_val,
   output logic              so_bit
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W-1);

   logic [BYTE_W-1:0] in_sh;
   logic [BYTE_W-1:0] out_sh;

   assign byte_val  = {in_sh[BYTE_W-2:0], si};
   assign byte_done = sck_rise && (bit_cnt == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         in_sh   <= '0;
         out_sh  <= '0;
         so_bit  <= 1'b0;
      end else if (!cs_active) begin
         bit_cnt <= '0;
         in_sh   <= '0;
         out_sh  <= '0;
         so_bit  <= 1'b0;
      end else begin
         if (sck_rise) begin
            in_sh   <= byte_val;
            bit_cnt <= bit_cnt + 1'b1;
         end
         if (sck_fall && load_en) begin
            if (bit_cnt == '0) begin
               so_bit <= load_data[BYTE_W-1];
               out_sh <= {load_data[BYTE_W-2:0], 1'b0};
            end else begin
               so_bit <= out_sh[BYTE_W-1];
               out_sh <= {out_sh[BYTE_W-2:0], 1'b0};
            end
         end
      end
   end
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
   import spi_regacc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LAST_REG = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_active,
   input  logic              byte_done,
   input  logic [BYTE_W-1:0] byte_val,
   input  logic [1:0]        strap_addr,
   input  logic              cfg_seq_hold,
   input  logic              cfg_addr_en,
   output phase_t            phase,
   output logic [ADDR_W-1:0] ptr,
   output logic              rf_we,
   output logic [ADDR_W-1:0] rf_waddr,
   output logic [BYTE_W-1:0] rf_wdata
);
   localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(LAST_REG);

   logic              is_read;
   logic              cmd_ok;
   logic [ADDR_W-1:0] ptr_next;

   assign cmd_ok = (byte_val[7:3] == CMD_PREFIX) &&
                   (!cfg_addr_en || (byte_val[2:1] == strap_addr));

   always_comb begin
      if (cfg_seq_hold)          ptr_next = ptr;
      else if (ptr == LAST_IDX)  ptr_next = '0;
      else                       ptr_next = ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_CMD;
         ptr      <= '0;
         is_read  <= 1'b0;
         rf_we    <= 1'b0;
         rf_waddr <= '0;
         rf_wdata <= '0;
      end else begin
         rf_we <= 1'b0;
         if (!cs_active) begin
            phase <= PH_CMD;
         end else if (byte_done) begin
            case (phase)
               PH_CMD: begin
                  if (cmd_ok) begin
                     is_read <= byte_val[0];
                     phase   <= PH_IDX;
                  end else begin
                     phase   <= PH_SKIP;
                  end
               end
               PH_IDX: begin
                  ptr   <= byte_val[ADDR_W-1:0];
                  phase <= is_read ? PH_RD : PH_WR;
               end
               PH_WR: begin
                  rf_we    <= 1'b1;
                  rf_waddr <= ptr;
                  rf_wdata <= byte_val;
                  ptr      <= ptr_next;
               end
               PH_RD: begin
                  ptr <= ptr_next;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/spi_regacc_slave.sv
module spi_regacc_slave
   import spi_regacc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LAST_REG = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_si,
   output logic              spi_so,
   output logic              spi_so_oe,
   input  logic [1:0]        strap_addr,
   input  logic              cfg_seq_hold,
   input  logic              cfg_addr_en,
   output logic [ADDR_W-1:0] rf_raddr,
   input  logic [7:0]        rf_rdata,
   output logic              rf_we,
   output logic [ADDR_W-1:0] rf_waddr,
   output logic [7:0]        rf_wdata
);
   localparam int CNT_W = $clog2(BYTE_W);

   if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_aw
      $error("spi_regacc_slave: ADDR_W must be 1..8");
   end
   if (LAST_REG < 0 || LAST_REG >= (1 << ADDR_W)) begin : g_bad_last
      $error("spi_regacc_slave: LAST_REG must fit in ADDR_W bits");
   end

   logic [2:0]        pins_s;
   logic              sck_s, cs_n_s, si_s, sck_d;
   logic              cs_active, sck_rise, sck_fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic              byte_done, so_bit;
   logic [BYTE_W-1:0] byte_val;
   phase_t            phase;
   logic [ADDR_W-1:0] ptr;

   spi_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) pin_sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d_in ({spi_sck, spi_cs_n, spi_si}),
      .d_out(pins_s)
   );

   assign {sck_s, cs_n_s, si_s} = pins_s;
   assign cs_active = !cs_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b0;
      else        sck_d <= sck_s;
   end

   assign sck_rise = cs_active && sck_s && !sck_d;
   assign sck_fall = cs_active && !sck_s && sck_d;

   spi_byte_shifter shifter_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_active(cs_active),
      .sck_rise (sck_rise),
      .sck_fall (sck_fall),
      .si       (si_s),
      .load_en  (phase == PH_RD),
      .load_data(rf_rdata),
      .bit_cnt  (bit_cnt),
      .byte_done(byte_done),
      .byte_val (byte_val),
      .so_bit   (so_bit)
   );

   spi_frame_ctrl #(.ADDR_W(ADDR_W), .LAST_REG(LAST_REG)) frame_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_active   (cs_active),
      .byte_done   (byte_done),
      .byte_val    (byte_val),
      .strap_addr  (strap_addr),
      .cfg_seq_hold(cfg_seq_hold),
      .cfg_addr_en (cfg_addr_en),
      .phase       (phase),
      .ptr         (ptr),
      .rf_we       (rf_we),
      .rf_waddr    (rf_waddr),
      .rf_wdata    (rf_wdata)
   );

   assign rf_raddr  = ptr;
   assign spi_so_oe = cs_active && (phase == PH_RD);
   assign spi_so    = spi_so_oe && so_bit;
endmodule

// File: rtl/spi_regacc_chk.sv
module spi_regacc_chk
   import spi_regacc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LAST_REG = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_active,
   input phase_t            phase,
   input logic [2:0]        bit_cnt,
   input logic              byte_done,
   input logic [ADDR_W-1:0] ptr,
   input logic              cfg_seq_hold,
   input logic              spi_so_oe,
   input logic              rf_we
);
   // R1: every write strobe lasts a single cycle
   a_r1_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> !rf_we);

   // R2: a rejected command stays silent for the rest of the frame
   a_r2_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SKIP) |-> (!rf_we && !spi_so_oe));

   // R4: pointer wraps from the last index to zero
   a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_active && byte_done && (phase inside {PH_WR, PH_RD}) &&
       (ptr == ADDR_W'(LAST_REG)) && !cfg_seq_hold) |=> (ptr == '0));

   // R5: pointer holds during data phases in hold mode
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_active && cfg_seq_hold && (phase inside {PH_WR, PH_RD})) |=> $stable(ptr));

   // R8: output enable only turns on right after the index byte
   a_r8_oe_after_idx: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_so_oe) |-> ($past(phase) == PH_IDX));

   // R9: chip select release clears the framing
   a_r9_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_active |=> ((phase == PH_CMD) && (bit_cnt == 3'd0)));
endmodule

bind spi_regacc_slave spi_regacc_chk #(.ADDR_W(ADDR_W), .LAST_REG(LAST_REG)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_active   (cs_active),
   .phase       (phase),
   .bit_cnt     (bit_cnt),
   .byte_done   (byte_done),
   .ptr         (ptr),
   .cfg_seq_hold(cfg_seq_hold),
   .spi_so_oe   (spi_so_oe),
   .rf_we       (rf_we)
);

// File: tb/spi_regacc_slave_tb_top.sv
module spi_regacc_slave_tb_top;
   localparam int NREG = 11;
   localparam int H = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b0, cs_n = 1'b1, si = 1'b0;
   logic       so, so_oe;
   logic [1:0] strap = 2'b00;
   logic       seq_hold = 1'b0, addr_en = 1'b0;
   logic [7:0] raddr, rdata, waddr, wdata;
   logic       we;

   logic [7:0] mem [NREG];
   logic [7:0] expv [NREG];
   logic [7:0] tx_buf [20];
   logic [7:0] rx_buf [20];
   logic       oe_seen [20];
   int         n_chk = 0, n_err = 0;

   always #10 clk = ~clk;

   spi_regacc_slave dut_i (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
      .spi_so(so), .spi_so_oe(so_oe), .strap_addr(strap),
      .cfg_seq_hold(seq_hold), .cfg_addr_en(addr_en),
      .rf_raddr(raddr), .rf_rdata(rdata), .rf_we(we),
      .rf_waddr(waddr), .rf_wdata(wdata)
   );

   assign rdata = (raddr < 8'(NREG)) ? mem[raddr[3:0]] : 8'h00;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) mem[i] <= 8'(i * 17 + 3);
      end else if (we && waddr < 8'(NREG)) begin
         mem[waddr[3:0]] <= wdata;
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // nbytes full bytes from tx_buf, then tail_bits of tx_buf[nbytes]
   task automatic frame(input int nbytes, input int tail_bits);
      int nb;
      nb = nbytes * 8 + tail_bits;
      for (int i = 0; i < 20; i++) begin rx_buf[i] = 8'h00; oe_seen[i] = 1'b0; end
      cs_n = 1'b0;
      wait_clk(H);
      for (int k = 0; k < nb; k++) begin
         si = tx_buf[k / 8][7 - (k % 8)];
         wait_clk(H);
         if (k % 8 == 0) oe_seen[k / 8] = so_oe;
         rx_buf[k / 8][7 - (k % 8)] = so;
         sck = 1'b1;
         wait_clk(H);
         sck = 1'b0;
      end
      wait_clk(H);
      cs_n = 1'b1;
      wait_clk(2 * H);
   endtask

   function automatic logic [7:0] cmd(input logic [1:0] a, input logic rd);
      return {5'b01000, a, rd};
   endfunction

   function automatic int nxt(input int p);
      return (p == NREG - 1) ? 0 : p + 1;
   endfunction

   task automatic check_mem(input string req);
      for (int i = 0; i < NREG; i++)
         chk(mem[i] == expv[i], req, mem[i], expv[i]);
   endtask

   initial begin
      wait_clk(3);
      chk(so_oe == 1'b0, "R8 reset oe", so_oe, 0);
      chk(we == 1'b0, "R1 reset we", we, 0);
      rst_n = 1'b1;
      wait_clk(3);
      for (int i = 0; i < NREG; i++) expv[i] = 8'(i * 17 + 3);

      // R3 / R1: sweep straps, select bits and matching enable
      for (int en = 0; en < 2; en++) begin
         for (int s = 0; s < 4; s++) begin
            for (int a = 0; a < 4; a++) begin
               logic [7:0] v;
               addr_en = en[0];
               strap = s[1:0];
               v = 8'h40 | 8'(en << 4) | 8'(s << 2) | 8'(a);
               tx_buf[0] = cmd(a[1:0], 1'b0);
               tx_buf[1] = 8'd2;
               tx_buf[2] = v;
               frame(3, 0);
               if (en == 0 || a == s) expv[2] = v;
               chk(mem[2] == expv[2], "R3 select decode", mem[2], expv[2]);
               chk(oe_seen[2] == 1'b0, "R8 oe low in write", oe_seen[2], 0);
            end
         end
      end
      addr_en = 1'b0;
      strap = 2'b00;

      // R2: every single-bit prefix corruption is rejected (write and read)
      for (int p = 0; p < 5; p++) begin
         tx_buf[0] = cmd(2'b00, 1'b0) ^ (8'h08 << p);
         tx_buf[1] = 8'd3;
         tx_buf[2] = 8'hC0 + 8'(p);
         frame(3, 0);
         chk(mem[3] == expv[3], "R2 bad prefix write", mem[3], expv[3]);
         tx_buf[0] = cmd(2'b00, 1'b1) ^ (8'h08 << p);
         frame(4, 0);
         chk(oe_seen[2] == 1'b0 && oe_seen[3] == 1'b0, "R2 bad prefix read oe", oe_seen[2], 0);
      end

      // R4 / R1: sequential write burst across the end of the map
      seq_hold = 1'b0;
      tx_buf[0] = cmd(2'b00, 1'b0);
      tx_buf[1] = 8'd5;
      begin
         int p;
         p = 5;
         for (int i = 0; i < 13; i++) begin
            tx_buf[2 + i] = 8'h90 + 8'(i);
            expv[p] = 8'h90 + 8'(i);
            p = nxt(p);
         end
      end
      frame(15, 0);
      check_mem("R4 sequential write wrap");

      // R6 / R4 / R8: sequential read across the end of the map
      tx_buf[0] = cmd(2'b00, 1'b1);
      tx_buf[1] = 8'd8;
      for (int i = 0; i < 14; i++) tx_buf[2 + i] = 8'hFF;
      frame(16, 0);
      chk(oe_seen[0] == 1'b0 && oe_seen[1] == 1'b0, "R8 oe low in cmd/idx", oe_seen[1], 0);
      begin
         int p;
         p = 8;
         for (int i = 0; i < 14; i++) begin
            chk(rx_buf[2 + i] == expv[p], "R6 R4 sequential read", rx_buf[2 + i], expv[p]);
            chk(oe_seen[2 + i] == 1'b1, "R8 oe high in read data", oe_seen[2 + i], 1);
            p = nxt(p);
         end
      end
      check_mem("R6 read has no side effect");

      // R5: hold mode write and read
      seq_hold = 1'b1;
      tx_buf[0] = cmd(2'b00, 1'b0);
      tx_buf[1] = 8'd4;
      tx_buf[2] = 8'h11; tx_buf[3] = 8'h22; tx_buf[4] = 8'h5A;
      frame(5, 0);
      expv[4] = 8'h5A;
      check_mem("R5 hold write");
      tx_buf[0] = cmd(2'b00, 1'b1);
      tx_buf[1] = 8'd10;
      frame(6, 0);
      for (int i = 0; i < 4; i++)
         chk(rx_buf[2 + i] == expv[10], "R5 hold read", rx_buf[2 + i], expv[10]);
      seq_hold = 1'b0;

      // R7: partial data byte is discarded
      for (int t = 1; t < 8; t++) begin
         tx_buf[0] = cmd(2'b00, 1'b0);
         tx_buf[1] = 8'd6;
         tx_buf[2] = 8'h3C;
         tx_buf[3] = 8'hE7;
         frame(3, t);
         expv[6] = 8'h3C;
         chk(mem[6] == expv[6] && mem[7] == expv[7], "R7 partial byte", mem[7], expv[7]);
      end

      // R9: aborted command bits do not leak into the next frame
      for (int t = 1; t < 8; t++) begin
         tx_buf[0] = 8'hFF;
         frame(0, t);
         tx_buf[0] = cmd(2'b00, 1'b0);
         tx_buf[1] = 8'd1;
         tx_buf[2] = 8'(8'hA0 + t);
         frame(3, 0);
         expv[1] = 8'(8'hA0 + t);
         chk(mem[1] == expv[1], "R9 framing reset", mem[1], expv[1]);
      end
      check_mem("R9 final map");

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule